// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Scheduler

This block decides when an SDRAM controller must refresh its memories. After its control register is first written, an interval counter runs in units of sixteen bus clocks. Each time it comes due, the block raises a refresh request toward the main command arbiter. When the arbiter grants the request, the block emits a one-cycle REF command strobe. It then holds off row activation (ACTV) for a programmable recovery time. The same recovery time and the same REF strobe serve both memory blocks behind the controller.

The block also places the memories into self-refresh and brings them out again. Setting a request bit in the control register makes the block issue a single SELF strobe and drive the clock-enable level low. Clearing the bit makes it issue a single SELFX strobe and drive clock-enable high again. While the memories refresh themselves, the interval counter is frozen, and it resumes from the same count afterwards. A mode bit declares that the clock-enable pin carries command data for external logic. In that mode the self-refresh request bit is disregarded, clock-enable stays high and periodic refresh continues.

Top module: `sdram_refresh_sched`

## Requirements
- R1: After reset, refReq, refCmd, selfCmd, selfExitCmd and actvBlock are 0 and ckeOut is 1. No refresh request is raised until the control register has been written once.
- R2: With interval field value RC, refReq rises N = (RC+1)*16 clock edges after the arming write edge or after the granting edge. An RC of 63 gives 1024 clocks.
- R3: refReq stays high until a clock edge samples refGrant=1. refCmd is then high for exactly the following cycle. A refGrant while refReq is low produces no refCmd and no lockout.
- R4: A refresh that comes due while one is still ungranted is kept as a second pending refresh, so refReq stays high after the first grant. The pending count saturates at two.
- R5: actvBlock is high for exactly G cycles starting with the refCmd cycle. G is selected by the 2-bit gap field: 00 gives 3, 01 gives 6, and 10 or 11 gives 9. The value in effect is the one held at the granting edge.
- R6: A new interval value written while the counter runs does not change the interval in progress. It applies from the next counter reload, whether that reload comes from expiry or from a grant.
- R7: With the self-refresh bit set and the clock-enable-command bit clear, the block issues one selfCmd pulse and ckeOut goes low in the same cycle. This happens only once no refresh is pending and actvBlock is low.
- R8: Clearing the self-refresh bit while in self-refresh produces exactly one selfExitCmd pulse, and ckeOut returns high in that same cycle.
- R9: While ckeOut is low the interval counter does not advance and no refresh is requested. After exit, refReq rises once the cycles counted outside self-refresh reach N.
- R10: With the clock-enable-command bit set, the self-refresh bit has no effect: there is no selfCmd, ckeOut stays high and refreshes keep being requested.
- R11: If a refresh comes due in the same cycle in which self-refresh entry would otherwise be taken, the refresh wins. The SELF strobe follows only after that REF has been granted and its lockout has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Writes the four control fields on this edge |
| cfgInterval | input | 9 | Refresh interval in 16-clock units minus one |
| cfgGapSel | input | 2 | ACTV lockout select (00:3, 01:6, 1x:9) |
| cfgSelfReq | input | 1 | Self-refresh request bit |
| cfgCkeCmd | input | 1 | Clock-enable carries command data |
| refGrant | input | 1 | Arbiter grant for the refresh request |
| refReq | output | 1 | Refresh request to the arbiter |
| refCmd | output | 1 | REF command strobe |
| selfCmd | output | 1 | SELF command strobe |
| selfExitCmd | output | 1 | SELFX command strobe |
| ckeOut | output | 1 | Clock-enable level |
| actvBlock | output | 1 | ACTV lockout after REF |

## Verification
Two functions can fall in the same cycle: the interval counter expiring, and a self-refresh request becoming eligible for entry. A directed sweep provokes this. With the arbiter granting at once, the self-refresh write is moved one edge at a time against the known expiry edge, so that one offset lands the request exactly on the expiry cycle. A cycle model in the bench, built from the requirements, judges every output in every cycle. Directed checks also confirm that REF precedes SELF at the colliding offset, and that SELF comes first one edge earlier.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic countEn;    // interval counter may advance this cycle
    logic grantTake;  // a pending refresh is granted this cycle
  } ctrlStrobe_t;

  // registered status from the datapath to the control FSM
  typedef struct packed {
    logic pendAny;     // at least one refresh pending
    logic lockIdle;    // ACTV lockout has elapsed
    logic expireNow;   // interval counter is at its last count
    logic selfWanted;  // self-refresh requested and allowed by mode
  } dpStatus_t;

  typedef enum logic [0:0] {
    ST_RUN  = 1'b0,
    ST_SELF = 1'b1
  } schedState_t;

endpackage

// File: rtl/refresh_datapath.sv
module refresh_datapath
  import refresh_sched_pkg::*;
#(
  parameter int RC_W       = 9,
  parameter int UNIT_SHIFT = 4,
  parameter int PEND_MAX   = 2,
  parameter int GAP_A      = 3,
  parameter int GAP_B      = 6,
  parameter int GAP_C      = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [RC_W-1:0]   cfgInterval,
  input  logic [1:0]        cfgGapSel,
  input  logic              cfgSelfReq,
  input  logic              cfgCkeCmd,
  input  ctrlStrobe_t       strobe,
  output dpStatus_t         status,
  output logic              actvBlock
);

  localparam int CNT_W   = RC_W + UNIT_SHIFT;
  localparam int PEND_W  = $clog2(PEND_MAX + 1);
  localparam int GAP_AB  = (GAP_A > GAP_B) ? GAP_A : GAP_B;
  localparam int GAP_MAX = (GAP_AB > GAP_C) ? GAP_AB : GAP_C;
  localparam int LOCK_W  = $clog2(GAP_MAX + 1);

  logic              armed;
  logic [RC_W-1:0]   rcReg;
  logic [1:0]        gapReg;
  logic              selfReg;
  logic              ckeCmdReg;
  logic [CNT_W-1:0]  cnt;
  logic [PEND_W-1:0] pend;
  logic [PEND_W-1:0] pendNext;
  logic [LOCK_W-1:0] lockCnt;
  logic              dueTick;

  // last count of an interval of (rc+1) units
  function automatic logic [CNT_W-1:0] lastCount(input logic [RC_W-1:0] rc);
    return {rc, {UNIT_SHIFT{1'b1}}};
  endfunction

  function automatic logic [LOCK_W-1:0] gapOf(input logic [1:0] sel);
    case (sel)
      2'b00:   return LOCK_W'(GAP_A);
      2'b01:   return LOCK_W'(GAP_B);
      default: return LOCK_W'(GAP_C);
    endcase
  endfunction

  // control register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      rcReg     <= '0;
      gapReg    <= '0;
      selfReg   <= 1'b0;
      ckeCmdReg <= 1'b0;
    end else if (cfgWrEn) begin
      armed     <= 1'b1;
      rcReg     <= cfgInterval;
      gapReg    <= cfgGapSel;
      selfReg   <= cfgSelfReq;
      ckeCmdReg <= cfgCkeCmd;
    end
  end

  assign dueTick = armed && strobe.countEn && (cnt == '0);

  // interval counter: loads on arming, on grant and on expiry
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!armed) begin
      if (cfgWrEn) cnt <= lastCount(cfgInterval);
    end else if (strobe.grantTake) begin
      cnt <= lastCount(rcReg);
    end else if (strobe.countEn) begin
      cnt <= (cnt == '0) ? lastCount(rcReg) : cnt - 1'b1;
    end
  end

  // pending refresh count
  always_comb begin
    pendNext = pend;
    case ({dueTick, strobe.grantTake})
      2'b10: if (pend != PEND_W'(PEND_MAX)) pendNext = pend + 1'b1;
      2'b01: pendNext = pend - 1'b1;
      default: pendNext = pend;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= pendNext;
  end

  // ACTV lockout counter
  always_ff @(posedge clk) begin
    if (!rst_n)                 lockCnt <= '0;
    else if (strobe.grantTake)  lockCnt <= gapOf(gapReg);
    else if (lockCnt != '0)     lockCnt <= lockCnt - 1'b1;
  end

  assign actvBlock         = (lockCnt != '0);
  assign status.pendAny    = (pend != '0);
  assign status.lockIdle   = (lockCnt == '0);
  assign status.expireNow  = armed && (cnt == '0);
  assign status.selfWanted = selfReg && !ckeCmdReg;

endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_sched_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        refGrant,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        refReq,
  output logic        refCmd,
  output logic        selfCmd,
  output logic        selfExitCmd,
  output logic        ckeOut
);

  schedState_t state;
  logic        enterSelf;
  logic        leaveSelf;

  // entry waits for a quiet cycle: nothing pending, no lockout, no expiry
  assign enterSelf = (state == ST_RUN) && status.selfWanted && !status.pendAny &&
                     status.lockIdle && !status.expireNow;
  assign leaveSelf = (state == ST_SELF) && !status.selfWanted;

  assign strobe.countEn   = (state == ST_RUN);
  assign strobe.grantTake = (state == ST_RUN) && refGrant && status.pendAny;
  assign refReq           = status.pendAny;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_RUN;
      refCmd      <= 1'b0;
      selfCmd     <= 1'b0;
      selfExitCmd <= 1'b0;
      ckeOut      <= 1'b1;
    end else begin
      refCmd      <= strobe.grantTake;
      selfCmd     <= enterSelf;
      selfExitCmd <= leaveSelf;
      if (enterSelf) begin
        state  <= ST_SELF;
        ckeOut <= 1'b0;
      end else if (leaveSelf) begin
        state  <= ST_RUN;
        ckeOut <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int RC_W       = 9,
  parameter int UNIT_SHIFT = 4,
  parameter int PEND_MAX   = 2,
  parameter int GAP_A      = 3,
  parameter int GAP_B      = 6,
  parameter int GAP_C      = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfgWrEn,
  input  logic [RC_W-1:0] cfgInterval,
  input  logic [1:0]      cfgGapSel,
  input  logic            cfgSelfReq,
  input  logic            cfgCkeCmd,
  input  logic            refGrant,
  output logic            refReq,
  output logic            refCmd,
  output logic            selfCmd,
  output logic            selfExitCmd,
  output logic            ckeOut,
  output logic            actvBlock
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  refresh_datapath #(
    .RC_W(RC_W), .UNIT_SHIFT(UNIT_SHIFT), .PEND_MAX(PEND_MAX),
    .GAP_A(GAP_A), .GAP_B(GAP_B), .GAP_C(GAP_C)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgInterval(cfgInterval),
    .cfgGapSel(cfgGapSel), .cfgSelfReq(cfgSelfReq), .cfgCkeCmd(cfgCkeCmd),
    .strobe(strobe), .status(status), .actvBlock(actvBlock)
  );

  refresh_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .refGrant(refGrant), .status(status),
    .strobe(strobe), .refReq(refReq), .refCmd(refCmd), .selfCmd(selfCmd),
    .selfExitCmd(selfExitCmd), .ckeOut(ckeOut)
  );

endmodule

// File: rtl/sdram_refresh_sched_chk.sv
module sdram_refresh_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic refGrant,
  input logic refReq,
  input logic refCmd,
  input logic selfCmd,
  input logic selfExitCmd,
  input logic ckeOut,
  input logic actvBlock
);

  // R3
  ref_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refCmd |-> $past(refReq && refGrant));

  // R5
  lock_with_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refCmd |-> actvBlock);

  // R7
  self_cke_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    selfCmd |-> !ckeOut);

  // R7
  cke_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ckeOut) |-> selfCmd);

  // R8
  exit_cke_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    selfExitCmd |-> ckeOut);

  // R7
  cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({refCmd, selfCmd, selfExitCmd}));

  // R9
  no_due_in_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ckeOut |-> !refReq);

endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk chk_i (
  .clk(clk), .rst_n(rst_n), .refGrant(refGrant), .refReq(refReq),
  .refCmd(refCmd), .selfCmd(selfCmd), .selfExitCmd(selfExitCmd),
  .ckeOut(ckeOut), .actvBlock(actvBlock)
);

// File: tb/sdram_refresh_sched_tb.sv
`timescale 1ns/1ps
module sdram_refresh_sched_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [8:0] cfgInterval = '0;
  logic [1:0] cfgGapSel = '0;
  logic       cfgSelfReq = 1'b0;
  logic       cfgCkeCmd = 1'b0;
  logic       refGrant = 1'b0;
  logic       refReq, refCmd, selfCmd, selfExitCmd, ckeOut, actvBlock;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sdram_refresh_sched dut_i (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgInterval(cfgInterval),
    .cfgGapSel(cfgGapSel), .cfgSelfReq(cfgSelfReq), .cfgCkeCmd(cfgCkeCmd),
    .refGrant(refGrant), .refReq(refReq), .refCmd(refCmd), .selfCmd(selfCmd),
    .selfExitCmd(selfExitCmd), .ckeOut(ckeOut), .actvBlock(actvBlock)
  );

  // ---------------- cycle model built from the requirements ----------------
  bit         mArmed, mInSelf, mSelf, mCkeCmd;
  bit         mRefCmd, mSelfCmd, mExitCmd, mCke;
  bit         mDue, mTake, mEnter, mLeave, mWant;
  logic [8:0] mRc;
  logic [1:0] mGap;
  int         mElapsed, mPeriod, mPend, mLock;

  function automatic int periodOf(input logic [8:0] rc);
    return (int'(rc) + 1) * 16;
  endfunction

  function automatic int gapOf(input logic [1:0] g);
    if (g == 2'b00) return 3;
    if (g == 2'b01) return 6;
    return 9;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mArmed = 0; mInSelf = 0; mSelf = 0; mCkeCmd = 0; mRc = '0; mGap = '0;
      mElapsed = 0; mPeriod = 16; mPend = 0; mLock = 0;
      mRefCmd = 0; mSelfCmd = 0; mExitCmd = 0; mCke = 1;
    end else begin
      mWant  = mSelf && !mCkeCmd;
      mDue   = mArmed && !mInSelf && (mElapsed == mPeriod - 1);
      mTake  = !mInSelf && refGrant && (mPend > 0);
      mEnter = !mInSelf && mWant && (mPend == 0) && (mLock == 0) && !mDue;
      mLeave = mInSelf && !mWant;
      if (!mArmed) begin
        if (cfgWrEn) begin mElapsed = 0; mPeriod = periodOf(cfgInterval); end
      end else if (mTake) begin
        mElapsed = 0; mPeriod = periodOf(mRc);
      end else if (!mInSelf) begin
        if (mDue) begin mElapsed = 0; mPeriod = periodOf(mRc); end
        else mElapsed++;
      end
      if (mDue && !mTake) mPend = (mPend < 2) ? mPend + 1 : 2;
      else if (mTake && !mDue) mPend--;
      if (mTake) mLock = gapOf(mGap);
      else if (mLock > 0) mLock--;
      mRefCmd = mTake; mSelfCmd = mEnter; mExitCmd = mLeave;
      if (mEnter) begin mCke = 0; mInSelf = 1; end
      if (mLeave) begin mCke = 1; mInSelf = 0; end
      if (cfgWrEn) begin
        mArmed = 1; mRc = cfgInterval; mGap = cfgGapSel;
        mSelf = cfgSelfReq; mCkeCmd = cfgCkeCmd;
      end
    end
  end

  task automatic chkBit(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chkInt(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chkBit("R2 refReq",      refReq,      mPend > 0);
      chkBit("R3 refCmd",      refCmd,      mRefCmd);
      chkBit("R5 actvBlock",   actvBlock,   mLock > 0);
      chkBit("R7 selfCmd",     selfCmd,     mSelfCmd);
      chkBit("R8 selfExitCmd", selfExitCmd, mExitCmd);
      chkBit("R7 ckeOut",      ckeOut,      mCke);
    end
  end

  // ---------------- stimulus helpers (called at a negedge) ----------------
  task automatic writeCfg(input int rc, input int gap, input bit sr, input bit kc);
    cfgInterval = 9'(rc); cfgGapSel = 2'(gap); cfgSelfReq = sr; cfgCkeCmd = kc;
    cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic waitReq();
    for (int i = 0; i < 5000 && !refReq; i++) @(negedge clk);
  endtask

  // one-cycle grant; returns at the negedge after the granting edge
  task automatic grantOnce();
    refGrant = 1'b1;
    @(negedge clk);
    refGrant = 1'b0;
  endtask

  task automatic countUntilReq(inout int k);
    while (!refReq && k < 5000) begin @(negedge clk); k++; end
  endtask

  initial begin
    int k, hi, runCyc, refSeen, selfSeen, refs;
    bit refFirst;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, nothing before the first write
    begin
      bit bad = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (refReq || refCmd || selfCmd || selfExitCmd || actvBlock || !ckeOut) bad = 1;
      end
      chkBit("R1 idle before arming", bad, 1'b0);
    end

    // R2: arming write to request, RC=2 -> 48 edges
    writeCfg(2, 0, 0, 0);
    k = 1; countUntilReq(k);
    chkInt("R2 interval after arming", k, 49);

    // R4: hold off the grant across two more expiries
    repeat (150) @(negedge clk);
    chkBit("R4 request held", refReq, 1'b1);
    grantOnce();
    chkBit("R3 refCmd after grant", refCmd, 1'b1);
    chkBit("R4 second pending kept", refReq, 1'b1);
    @(negedge clk);
    chkBit("R3 refCmd single pulse", refCmd, 1'b0);
    grantOnce();
    chkBit("R4 pending drained", refReq, 1'b0);

    // R3: grant with no request is ignored
    repeat (12) @(negedge clk);
    grantOnce();
    chkBit("R3 stray grant no refCmd", refCmd, 1'b0);
    chkBit("R3 stray grant no lockout", actvBlock, 1'b0);

    // R5: lockout length for every code
    for (int g = 0; g < 4; g++) begin
      writeCfg(2, g, 0, 0);
      waitReq();
      grantOnce();
      hi = 0;
      while (actvBlock && hi < 20) begin hi++; @(negedge clk); end
      chkInt($sformatf("R5 lockout code %0d", g), hi, gapOf(2'(g)));
    end

    // R6: new interval applies only from the next reload
    waitReq();
    grantOnce();
    writeCfg(5, 0, 0, 0);
    k = 2; countUntilReq(k);
    chkInt("R6 old interval kept", k, 49);
    grantOnce();
    k = 1; countUntilReq(k);
    chkInt("R6 new interval after reload", k, 97);

    // R2: RC of 63 gives 1024 clocks
    writeCfg(63, 0, 0, 0);
    grantOnce();
    k = 1; countUntilReq(k);
    chkInt("R2 interval of 1024", k, 1025);

    // R7, R8, R9: self-refresh with the counter frozen
    writeCfg(2, 0, 0, 0);
    grantOnce();
    k = 1; countUntilReq(k);
    grantOnce();
    runCyc = 1;
    repeat (9) begin @(negedge clk); runCyc++; end
    cfgInterval = 9'd2; cfgGapSel = 2'd0; cfgSelfReq = 1'b1; cfgCkeCmd = 1'b0;
    cfgWrEn = 1'b1;
    @(negedge clk); cfgWrEn = 1'b0;
    selfSeen = 0;
    for (int i = 0; i < 200; i++) begin
      if (ckeOut) runCyc++;
      if (selfCmd) selfSeen++;
      @(negedge clk);
    end
    chkInt("R7 single SELF strobe", selfSeen, 1);
    chkBit("R7 cke low in self-refresh", ckeOut, 1'b0);
    chkBit("R9 no request while frozen", refReq, 1'b0);
    cfgSelfReq = 1'b0; cfgWrEn = 1'b1;
    if (ckeOut) runCyc++;
    @(negedge clk); cfgWrEn = 1'b0;
    hi = 0;
    while (!refReq && runCyc < 500) begin
      if (selfExitCmd) begin
        hi++;
        chkBit("R8 cke high with SELFX", ckeOut, 1'b1);
      end
      if (ckeOut) runCyc++;
      @(negedge clk);
    end
    chkInt("R8 single SELFX strobe", hi, 1);
    chkInt("R9 counted run cycles", runCyc, 48);

    // R10: clock-enable carries commands, self bit ignored
    refGrant = 1'b1;
    writeCfg(0, 0, 1, 1);
    selfSeen = 0; refs = 0; hi = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (selfCmd) selfSeen++;
      if (!ckeOut) hi++;
      if (refCmd) refs++;
    end
    chkInt("R10 no SELF in command mode", selfSeen, 0);
    chkInt("R10 cke never low", hi, 0);
    chkBit("R10 refreshes continue", refs >= 10, 1'b1);
    writeCfg(0, 0, 0, 0);

    // R11: sweep self request against the expiry edge
    for (int off = 0; off < 18; off++) begin
      for (int i = 0; i < 100 && !refCmd; i++) @(negedge clk);
      repeat (off) @(negedge clk);
      writeCfg(0, 0, 1, 0);
      refFirst = 0;
      for (int i = 0; i < 100 && !selfCmd; i++) begin
        if (refCmd) refFirst = 1;
        @(negedge clk);
      end
      if (off == 13) chkBit("R11 SELF before expiry", refFirst, 1'b0);
      if (off == 14) chkBit("R11 REF wins collision", refFirst, 1'b1);
      writeCfg(0, 0, 0, 0);
      repeat (3) @(negedge clk);
    end
    refGrant = 1'b0;

    // random mix
    for (int i = 0; i < 3000; i++) begin
      refGrant = ($urandom % 4) == 0;
      if (($urandom % 40) == 0)
        writeCfg(int'($urandom % 4), int'($urandom % 4),
                 ($urandom % 3) == 0, ($urandom % 4) == 0);
      else
        @(negedge clk);
    end
    refGrant = 1'b0;
    repeat (5) @(negedge clk);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

endmodule